// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

This block collects a set of level-sensitive interrupt lines into three 32-bit registers: a pending register that records any line seen high, a mask register chosen by software, and a sticky request register that records lines which rose while unmasked. Instead of driving an interrupt wire, the block reports an unmasked rising line by issuing one 32-bit write on a small valid/ready master port. The address of that write is the target register with its low five bits cleared. The data of that write is the low five bits of the same register, which acts as an interrupt number.

Software reaches the registers through a word-wide register port. `reg_wr` and `reg_rd` are single-cycle strobes with a byte offset. Read data is registered and appears one cycle after the read strobe. The pending register clears whenever it is read or written. A bus-error bit in the control register suppresses message writes while it is set.

The sender is a two-state machine. In `ST_IDLE` no write is offered. The transition `launch` (an unmasked rise while the inhibit bit is clear) moves it to `ST_SEND`, where `msg_valid` is high. In `ST_SEND`, `accept_idle` (ready with nothing queued) returns it to `ST_IDLE`. `accept_resend` (ready with the resend flag set or a new launch) stays in `ST_SEND` and loads a fresh beat. `stall` (ready low) stays in `ST_SEND` and sets the resend flag if a launch arrives.

Top module: `msi_irq_aggregator`

## Requirements
- R1: After reset, REQ (offset 0x00), MASK (0x04), PEND (0x08) and CTRL (0x0C) read 0, TARGET (0x10) reads 0xFFFB0003, and `msg_valid` is low.
- R2: In every cycle in which a line is high, its PEND bit is set, whether or not the line is masked.
- R3: A 0-to-1 transition of a line whose MASK bit is 1 sets that REQ bit and requests a message. A rise on a masked-out line (MASK bit 0) sets no REQ bit and sends nothing. REQ bits are cleared only by reset.
- R4: A message write has `msg_addr` = TARGET with bits [4:0] forced to 0 and `msg_data` = TARGET[4:0] zero-extended. The data word is big-endian: `msg_data[31:24]` is the byte at the lowest address.
- R5: While CTRL bit 8 (bus-error inhibit) is 1, an unmasked rise sets its REQ bit but starts no message write.
- R6: A read of PEND returns its value and then clears it. A write to PEND clears it whatever the data. A line that is high in the same cycle as the clear keeps its bit set.
- R7: A read of CTRL returns only bit 8. All other bits read 0.
- R8: Writes to REQ are ignored. Accesses to unlisted offsets change no register, and reads of them return 0.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold steady.
- R10: Launches that arrive while a write is outstanding are merged into exactly one further write, issued after the outstanding one is accepted.
- R11: `reg_rdata` shows the addressed register in the cycle after `reg_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Level interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| msg_valid | output | 1 | Message write offered |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data, big-endian word |

## Verification
Single-cycle pulses on unmasked lines are compared with pulses on masked-out lines. This shows that the mask gates REQ and the message port but not PEND. The same unmasked pulse is repeated with the inhibit bit set, which shows that the inhibit bit blocks only the write and not the REQ update. A line held high across PEND reads, and two targets with different low bits, show that set-wins-over-clear works and that the address and data are split correctly. A burst of rises under a stalled `msg_ready` shows that several launches merge into exactly one extra beat and that the offered beat stays stable.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
    localparam int REG_W       = 32;
    localparam int BUSERR_BIT  = 8;
    localparam int NUM_LSB     = 5;
    localparam logic [REG_W-1:0] TARGET_RST = 32'hFFFB_0003;

    localparam logic [7:0] OFF_REQ    = 8'h00;
    localparam logic [7:0] OFF_MASK   = 8'h04;
    localparam logic [7:0] OFF_PEND   = 8'h08;
    localparam logic [7:0] OFF_CTRL   = 8'h0C;
    localparam logic [7:0] OFF_TARGET = 8'h10;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } send_state_t;

    typedef struct packed {
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] data;
    } msg_beat_t;
endpackage

// File: rtl/msi_src_latch.sv
module msi_src_latch #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] mask,
    input  logic               pend_clr,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] req,
    output logic               fire
);
    logic [NUM_SRC-1:0] prev;
    logic [NUM_SRC-1:0] rise_hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign rise_hit[i] = irq_in[i] & ~prev[i] & mask[i];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev[i] <= 1'b0;
                pend[i] <= 1'b0;
                req[i]  <= 1'b0;
            end else begin
                prev[i] <= irq_in[i];
                pend[i] <= irq_in[i] | (pend[i] & ~pend_clr);
                if (rise_hit[i]) begin
                    req[i] <= 1'b1;
                end
            end
        end
    end

    assign fire = |rise_hit;

    p_pend_follows_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in != '0) |=> ((pend & $past(irq_in)) == $past(irq_in)));

    p_req_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |=> ((req & $past(req)) == $past(req)));

    p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr && (irq_in == '0)) |=> (pend == '0));
endmodule

// File: rtl/msi_regs.sv
module msi_regs
    import msi_agg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [REG_W-1:0] pend_word,
    input  logic [REG_W-1:0] req_word,
    output logic [REG_W-1:0] mask,
    output logic             buserr,
    output logic [REG_W-1:0] target,
    output logic             pend_clr,
    output logic [REG_W-1:0] reg_rdata
);
    localparam logic [REG_W-1:0] BUSERR_MASK = REG_W'(1) << BUSERR_BIT;

    logic hit_req, hit_mask, hit_pend, hit_ctrl, hit_target;
    logic [REG_W-1:0] rd_mux;

    assign hit_req    = (reg_addr == ADDR_W'(OFF_REQ));
    assign hit_mask   = (reg_addr == ADDR_W'(OFF_MASK));
    assign hit_pend   = (reg_addr == ADDR_W'(OFF_PEND));
    assign hit_ctrl   = (reg_addr == ADDR_W'(OFF_CTRL));
    assign hit_target = (reg_addr == ADDR_W'(OFF_TARGET));

    assign pend_clr = (reg_wr | reg_rd) & hit_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask   <= '0;
            buserr <= 1'b0;
            target <= TARGET_RST;
        end else if (reg_wr) begin
            if (hit_mask)   mask   <= reg_wdata;
            if (hit_ctrl)   buserr <= reg_wdata[BUSERR_BIT];
            if (hit_target) target <= reg_wdata;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_req)    rd_mux = req_word;
        if (hit_mask)   rd_mux = mask;
        if (hit_pend)   rd_mux = pend_word;
        if (hit_ctrl)   rd_mux = buserr ? BUSERR_MASK : '0;
        if (hit_target) rd_mux = target;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

    p_ctrl_read_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && hit_ctrl) |=> ((reg_rdata & ~BUSERR_MASK) == '0));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

// File: rtl/msi_send_fsm.sv
module msi_send_fsm
    import msi_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [REG_W-1:0] target,
    input  logic             msg_ready,
    output logic             msg_valid,
    output logic [REG_W-1:0] msg_addr,
    output logic [REG_W-1:0] msg_data
);
    send_state_t state, state_nx;
    logic        again, again_nx;
    logic        load;
    msg_beat_t   beat, beat_nx;

    always_comb begin
        beat_nx.addr = {target[REG_W-1:NUM_LSB], {NUM_LSB{1'b0}}};
        beat_nx.data = {{(REG_W-NUM_LSB){1'b0}}, target[NUM_LSB-1:0]};
    end

    always_comb begin
        state_nx = state;
        again_nx = again;
        load     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (launch) begin
                    state_nx = ST_SEND;
                    load     = 1'b1;
                end
            end
            ST_SEND: begin
                if (msg_ready) begin
                    if (again || launch) begin
                        load     = 1'b1;
                        again_nx = 1'b0;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end else if (launch) begin
                    again_nx = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            again <= 1'b0;
            beat  <= '0;
        end else begin
            state <= state_nx;
            again <= again_nx;
            if (load) beat <= beat_nx;
        end
    end

    always_comb begin
        msg_valid = (state == ST_SEND);
        msg_addr  = beat.addr;
        msg_data  = beat.data;
    end

    p_hold_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    p_queued_resend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && again) |=> msg_valid);

    p_addr_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[NUM_LSB-1:0] == '0));
endmodule

// File: rtl/msi_irq_aggregator.sv
module msi_irq_aggregator
    import msi_agg_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [31:0]        msg_addr,
    output logic [31:0]        msg_data
);
    logic [NUM_SRC-1:0] pend, req;
    logic [REG_W-1:0]   pend_word, req_word, mask, target;
    logic               pend_clr, buserr, fire, launch;

    always_comb begin
        pend_word = '0;
        req_word  = '0;
        pend_word[NUM_SRC-1:0] = pend;
        req_word[NUM_SRC-1:0]  = req;
    end

    msi_src_latch #(.NUM_SRC(NUM_SRC)) u_src (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask(mask[NUM_SRC-1:0]),
        .pend_clr(pend_clr), .pend(pend), .req(req), .fire(fire)
    );

    msi_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pend_word(pend_word),
        .req_word(req_word), .mask(mask), .buserr(buserr), .target(target),
        .pend_clr(pend_clr), .reg_rdata(reg_rdata)
    );

    assign launch = fire & ~buserr;

    msi_send_fsm u_send (
        .clk(clk), .rst_n(rst_n), .launch(launch), .target(target),
        .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_addr(msg_addr),
        .msg_data(msg_data)
    );

    p_inhibit_blocks_send_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_valid && fire && buserr) |=> !msg_valid);

    p_fire_starts_send_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_valid && launch) |=> msg_valid);
endmodule

// File: tb/msi_irq_aggregator_test.sv
module msi_irq_aggregator_test;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_in = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          msg_valid, msg_ready = 1'b1;
    logic [31:0]   msg_addr, msg_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [63:0] exp_q[$];

    always #10 clk = ~clk;

    msi_irq_aggregator #(.NUM_SRC(NS), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input int bitn);
        @(negedge clk);
        irq_in[bitn] = 1'b1;
        @(negedge clk);
        irq_in[bitn] = 1'b0;
    endtask

    function automatic logic [63:0] expect_of(input logic [31:0] t);
        return {t & 32'hFFFF_FFE0, t & 32'h0000_001F};
    endfunction

    // monitor: one accepted beat per negedge with valid and ready
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rst_n && msg_valid && msg_ready) begin
                if (exp_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R3/R5/R10 unexpected message actual=%h_%h expected=none",
                             msg_addr, msg_data);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    check("R4 msg_addr", msg_addr, e[63:32]);
                    check("R4 msg_data", msg_data, e[31:0]);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        check("R1 msg_valid", {31'b0, msg_valid}, 32'h0);
        rd(8'h00, v); check("R1 REQ", v, 32'h0);
        rd(8'h04, v); check("R1 MASK", v, 32'h0);
        rd(8'h08, v); check("R1 PEND", v, 32'h0);
        rd(8'h0C, v); check("R1 CTRL", v, 32'h0);
        rd(8'h10, v); check("R1 TARGET", v, 32'hFFFB_0003);

        // R3/R4 unmasked rise
        wr(8'h10, 32'h0000_1047);
        wr(8'h04, 32'h0000_0005);
        exp_q.push_back(expect_of(32'h0000_1047));
        pulse(0);
        repeat (3) @(negedge clk);
        rd(8'h00, v); check("R3 REQ after unmasked rise", v, 32'h1);
        check("R11 rdata holds", reg_rdata, 32'h1);
        rd(8'h08, v); check("R2 PEND bit0", v, 32'h1);
        rd(8'h08, v); check("R6 PEND cleared by read", v, 32'h0);

        // R2/R3 masked-out rise
        pulse(1);
        repeat (3) @(negedge clk);
        rd(8'h08, v); check("R2 PEND masked line", v, 32'h2);
        rd(8'h00, v); check("R3 REQ unchanged by masked line", v, 32'h1);

        // R5/R7 inhibit
        wr(8'h0C, 32'h0000_01FF);
        rd(8'h0C, v); check("R7 CTRL reads bit8 only", v, 32'h0000_0100);
        pulse(2);
        repeat (3) @(negedge clk);
        rd(8'h00, v); check("R5 REQ set while inhibited", v, 32'h5);
        wr(8'h0C, 32'h0);
        rd(8'h0C, v); check("R7 CTRL cleared", v, 32'h0);

        // R6 write clears, set wins over clear
        wr(8'h08, 32'hDEAD_BEEF);
        rd(8'h08, v); check("R6 PEND cleared by write", v, 32'h0);
        @(negedge clk); irq_in[1] = 1'b1;
        rd(8'h08, v); check("R6 PEND line held first read", v, 32'h2);
        rd(8'h08, v); check("R6 set wins over clear", v, 32'h2);
        @(negedge clk); irq_in[1] = 1'b0;
        rd(8'h08, v); check("R6 last set visible", v, 32'h2);
        rd(8'h08, v); check("R6 PEND empty after release", v, 32'h0);

        // R8 ignored writes
        wr(8'h00, 32'h0);
        rd(8'h00, v); check("R8 REQ write ignored", v, 32'h5);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, v); check("R8 unlisted reads zero", v, 32'h0);
        rd(8'h04, v); check("R8 MASK untouched", v, 32'h5);
        rd(8'h10, v); check("R8 TARGET untouched", v, 32'h0000_1047);

        // R9/R10 stall and merge
        wr(8'h10, 32'h2000_001F);
        @(negedge clk); msg_ready = 1'b0;
        exp_q.push_back(expect_of(32'h2000_001F));
        exp_q.push_back(expect_of(32'h2000_001F));
        pulse(0);
        held = msg_addr;
        check("R9 valid raised", {31'b0, msg_valid}, 32'h1);
        pulse(2);
        pulse(2);
        pulse(0);
        check("R9 valid held", {31'b0, msg_valid}, 32'h1);
        check("R9 addr stable", msg_addr, held);
        check("R9 data stable", msg_data, 32'h0000_001F);
        @(negedge clk); msg_ready = 1'b1;
        repeat (6) @(negedge clk);
        check("R10 exactly one extra beat", exp_q.size(), 32'h0);
        check("R10 port idle", {31'b0, msg_valid}, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule